// File: doc/BRIEF.md
# Program Sequencer with Return Stack

This block sequences the instruction fetch address of a small processor with 12-bit instruction words and a 2048-word program space. It holds an 11-bit program counter. Each ordinary instruction moves the counter forward by one. Jumps, calls, direct writes of the low counter byte and returns redirect it. A redirect builds the new address from an 8-bit low part, taken from the instruction or from the written byte, and a 3-bit page value supplied from the processor's status register. A call saves the address that follows it on an eight-entry hidden return stack, and a return restores it. Software has no read or write path to that stack.

Every redirect and every taken skip costs two cycles. The cycle after the change is a flush cycle, during which `stall` is high. The decoder must treat the instruction fetched in that cycle as a no-op. A small state machine with two states controls this. In RUN, commands are accepted, and any redirecting command or taken skip moves the machine to FLUSH (transition "redirect"). FLUSH lasts exactly one cycle, ignores every command, and always returns to RUN (transition "resume"). Any other cycle in RUN stays in RUN (transition "step").

Top module: `pc_sequencer`

## Requirements
- R1: After reset, `fetch_addr` is 0, `stall` is 0, the return stack is empty, and the remembered last-popped value is 0.
- R2: In RUN, `advance` alone increments `fetch_addr` by 1, modulo 2048, at the next clock edge. With no command asserted, `fetch_addr` holds and `stall` stays 0.
- R3: `jump` loads `fetch_addr` with {`page`, `target`}: `page` forms bits 10:8 and `target` forms bits 7:0. The following cycle has `stall` high.
- R4: `pc_write` loads `fetch_addr` with {`page`, `target`} in the same way as a jump, and the following cycle has `stall` high.
- R5: `skip` (a taken test-and-skip) increments `fetch_addr` by 2, modulo 2048, and the following cycle has `stall` high.
- R6: `call` pushes `fetch_addr`+1 (modulo 2048) onto the return stack, loads {`page`, `target`}, and the following cycle has `stall` high.
- R7: `ret` loads `fetch_addr` with the most recently pushed entry that has not yet been popped, and the following cycle has `stall` high.
- R8: The stack holds eight entries in last-in, first-out order.
- R9: A push onto a full stack overwrites the oldest entry. The eight entries that remain are then popped newest first.
- R10: A return on an empty stack reloads the value that the last successful pop produced, or 0 if none has occurred since reset. No flag is raised.
- R11: During a stall cycle, all command inputs are ignored. `fetch_addr` holds, and the stack is unchanged.
- R12: When several commands are asserted together, priority is `ret` > `call` > `jump` > `pc_write` > `skip` > `advance`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| advance | input | 1 | Ordinary instruction completes; step by one |
| skip | input | 1 | Taken test-and-skip; step by two |
| jump | input | 1 | Load jump target |
| call | input | 1 | Push return address and load target |
| ret | input | 1 | Pop return address |
| pc_write | input | 1 | Software write of the low counter byte |
| target | input | 8 | Low address byte for jump, call and write |
| page | input | 3 | Page-select bits from the status register |
| fetch_addr | output | 11 | Current instruction fetch address |
| stall | output | 1 | High during the flush cycle after a redirect or skip |

## Verification
A sweep of more than 2048 consecutive advances covers every counter value and the wrap from 2047 to 0. Skips placed at 2046 and 2047 show that the step of two wraps in the same way. Jumps and writes are swept across all eight pages with several low bytes, which shows that the page bits and the low byte land in the right fields. Every redirect is followed by a flush cycle in which all commands are asserted, so that commands which are not ignored show up as a moved address or as a corrupted stack. Call chains of eight and of nine, followed by a surplus of returns, separate plain last-in, first-out order, overwrite of the oldest entry, and the empty-pop reload. Simultaneous commands confirm the priority order.

// File: rtl/pcseq_pkg.sv
package pcseq_pkg;
    typedef enum logic [2:0] {
        OP_HOLD,
        OP_INC,
        OP_SKIP,
        OP_WRPC,
        OP_JUMP,
        OP_CALL,
        OP_RET
    } op_e;

    typedef enum logic {
        S_RUN,
        S_FLUSH
    } seq_state_e;
endpackage

// File: rtl/pcseq_ctrl.sv
module pcseq_ctrl
    import pcseq_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic advance,
    input  logic skip,
    input  logic jump,
    input  logic call,
    input  logic ret,
    input  logic pc_write,
    output op_e  op,
    output logic stall
);
    seq_state_e state_q, state_d;

    // State register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= S_RUN;
        else        state_q <= state_d;
    end

    // Outputs and next state
    always_comb begin
        op      = OP_HOLD;
        stall   = 1'b0;
        state_d = state_q;
        unique case (state_q)
            S_RUN: begin
                if      (ret)      op = OP_RET;
                else if (call)     op = OP_CALL;
                else if (jump)     op = OP_JUMP;
                else if (pc_write) op = OP_WRPC;
                else if (skip)     op = OP_SKIP;
                else if (advance)  op = OP_INC;
                if (op != OP_HOLD && op != OP_INC) state_d = S_FLUSH;
            end
            S_FLUSH: begin
                stall   = 1'b1;
                state_d = S_RUN;
            end
        endcase
    end

    p_flush_single_r3: assert property (@(posedge clk) disable iff (!rst_n)
        state_q == S_FLUSH |=> state_q == S_RUN);
    p_redirect_flush_r12: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == S_RUN && (ret || call || jump || pc_write || skip)) |=> state_q == S_FLUSH);
endmodule

// File: rtl/pcseq_stack.sv
module pcseq_stack #(
    parameter int W     = 11,
    parameter int DEPTH = 8
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         push,
    input  logic         pop,
    input  logic [W-1:0] push_data,
    output logic [W-1:0] pop_data
);
    localparam int PW = $clog2(DEPTH);
    localparam logic [PW:0] FULL = (PW+1)'(DEPTH);

    logic [DEPTH-1:0][W-1:0] mem_q;
    logic [PW-1:0] sp_q;
    logic [PW:0]   cnt_q;
    logic [W-1:0]  last_q;
    logic [PW-1:0] top_idx;

    assign top_idx  = sp_q - 1'b1;
    assign pop_data = (cnt_q != '0) ? mem_q[top_idx] : last_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            mem_q  <= '0;
            sp_q   <= '0;
            cnt_q  <= '0;
            last_q <= '0;
        end else if (push) begin
            mem_q[sp_q] <= push_data;
            sp_q        <= sp_q + 1'b1;
            if (cnt_q != FULL) cnt_q <= cnt_q + 1'b1;
        end else if (pop && cnt_q != '0) begin
            sp_q   <= top_idx;
            cnt_q  <= cnt_q - 1'b1;
            last_q <= mem_q[top_idx];
        end
    end

    p_count_bound_r9: assert property (@(posedge clk) disable iff (!rst_n)
        cnt_q <= FULL);
    p_push_grow_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (push && cnt_q != FULL) |=> cnt_q == $past(cnt_q) + 1'b1);
    p_pop_shrink_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (pop && !push && cnt_q != '0) |=> cnt_q == $past(cnt_q) - 1'b1);
    p_empty_pop_r10: assert property (@(posedge clk) disable iff (!rst_n)
        (pop && !push && cnt_q == '0) |=> (cnt_q == '0 && $stable(last_q)));
endmodule

// File: rtl/pc_sequencer.sv
module pc_sequencer
    import pcseq_pkg::*;
#(
    parameter int ADDR_W = 11,
    parameter int LOW_W  = 8,
    parameter int DEPTH  = 8
) (
    input  logic                    clk,
    input  logic                    rst_n,
    input  logic                    advance,
    input  logic                    skip,
    input  logic                    jump,
    input  logic                    call,
    input  logic                    ret,
    input  logic                    pc_write,
    input  logic [LOW_W-1:0]        target,
    input  logic [ADDR_W-LOW_W-1:0] page,
    output logic [ADDR_W-1:0]       fetch_addr,
    output logic                    stall
);
    localparam int PAGE_W = ADDR_W - LOW_W;

    op_e               op;
    logic [ADDR_W-1:0] pc_q;
    logic [ADDR_W-1:0] pop_data;
    logic [ADDR_W-1:0] load_addr;

    pcseq_ctrl u_ctrl (
        .clk      (clk),
        .rst_n    (rst_n),
        .advance  (advance),
        .skip     (skip),
        .jump     (jump),
        .call     (call),
        .ret      (ret),
        .pc_write (pc_write),
        .op       (op),
        .stall    (stall)
    );

    pcseq_stack #(.W(ADDR_W), .DEPTH(DEPTH)) u_stack (
        .clk       (clk),
        .rst_n     (rst_n),
        .push      (op == OP_CALL),
        .pop       (op == OP_RET),
        .push_data (pc_q + 1'b1),
        .pop_data  (pop_data)
    );

    assign load_addr = {page[PAGE_W-1:0], target};

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) pc_q <= '0;
        else begin
            unique case (op)
                OP_HOLD: pc_q <= pc_q;
                OP_INC:  pc_q <= pc_q + 1'b1;
                OP_SKIP: pc_q <= pc_q + 2'd2;
                OP_WRPC, OP_JUMP, OP_CALL: pc_q <= load_addr;
                OP_RET:  pc_q <= pop_data;
                default: pc_q <= pc_q;
            endcase
        end
    end

    assign fetch_addr = pc_q;

    p_hold_in_stall_r11: assert property (@(posedge clk) disable iff (!rst_n)
        stall |=> fetch_addr == $past(fetch_addr));
    p_step_one_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (!stall && advance && !(skip || jump || call || ret || pc_write))
        |=> fetch_addr == ADDR_W'($past(fetch_addr) + 1'b1));
    p_load_target_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (!stall && jump && !call && !ret) |=> fetch_addr == $past({page, target}));
endmodule

// File: tb/tb_pc_sequencer.sv
`timescale 1ns/1ps
module tb_pc_sequencer;
    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic advance = 0, skip = 0, jump = 0, call = 0, ret = 0, pc_write = 0;
    logic [7:0] target = '0;
    logic [2:0] page = '0;
    logic [10:0] fetch_addr;
    logic stall;

    int checks = 0, errors = 0;
    int exp_pc = 0;
    int stk [8];
    int sp = 0, cnt = 0, last = 0;

    always #4 clk = ~clk;

    pc_sequencer dut (.*);

    task automatic chk(string req, int act, int expv);
        checks++;
        if (act != expv) begin
            errors++;
            $display("FAIL %s: actual %0d expected %0d", req, act, expv);
        end
    endtask

    task automatic clear_in();
        advance = 0; skip = 0; jump = 0; call = 0; ret = 0; pc_write = 0;
    endtask

    // Issue one command cycle (called at a negedge); model, then check.
    task automatic issue(input bit a, s, j, c, r, w,
                         input int tgt, input int pg, input string req);
        bit redir;
        advance = a; skip = s; jump = j; call = c; ret = r; pc_write = w;
        target = 8'(tgt); page = 3'(pg);
        redir = 1;
        if (r) begin
            if (cnt > 0) begin sp = (sp + 7) % 8; last = stk[sp]; cnt--; end
            exp_pc = last;
        end else if (c) begin
            stk[sp] = (exp_pc + 1) % 2048; sp = (sp + 1) % 8;
            if (cnt < 8) cnt++;
            exp_pc = pg * 256 + tgt;
        end else if (j || w) exp_pc = pg * 256 + tgt;
        else if (s) exp_pc = (exp_pc + 2) % 2048;
        else begin
            redir = 0;
            if (a) exp_pc = (exp_pc + 1) % 2048;
        end
        @(negedge clk);
        clear_in();
        chk(req, fetch_addr, exp_pc);
        chk(req, stall, redir);
        if (redir) begin
            // Flush cycle: everything asserted must be ignored (R11)
            advance = 1; skip = 1; jump = 1; call = 1; ret = 1; pc_write = 1;
            target = 8'hA5; page = 3'd5;
            @(negedge clk);
            clear_in();
            chk("R11", fetch_addr, exp_pc);
            chk("R11", stall, 0);
        end
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        errors++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        chk("R1", fetch_addr, 0);
        chk("R1", stall, 0);
        // Empty pop right after reset reloads 0 (R1, R10)
        issue(0,0,0,0,1,0, 0,0, "R10");
        // Idle cycle holds (R2)
        @(negedge clk);
        chk("R2", fetch_addr, exp_pc);
        chk("R2", stall, 0);
        // Full advance sweep with wrap (R2)
        for (int i = 0; i < 2050; i++) issue(1,0,0,0,0,0, 0,0, "R2");
        // Jumps and writes across all pages (R3, R4)
        for (int pg = 0; pg < 8; pg++) begin
            issue(0,0,1,0,0,0, (pg * 37 + 3) % 256, pg, "R3");
            issue(0,0,0,0,0,1, 255 - pg, 7 - pg, "R4");
        end
        // Skips including wrap (R5)
        issue(0,0,1,0,0,0, 254, 7, "R3");
        issue(0,0,0,0,0,0, 0,0, "R2");
        issue(0,1,0,0,0,0, 0,0, "R5");
        issue(0,1,0,0,0,0, 0,0, "R5");
        issue(0,0,1,0,0,0, 255, 7, "R3");
        issue(0,1,0,0,0,0, 0,0, "R5");
        // Priority (R12)
        issue(1,1,1,1,0,1, 16, 1, "R12");
        issue(1,1,1,0,0,1, 32, 2, "R12");
        issue(1,1,0,0,0,1, 48, 3, "R12");
        issue(1,1,0,0,1,1, 64, 4, "R12");
        issue(1,1,0,0,0,0, 0, 0, "R12");
        // Nested calls, depth 8 (R6, R8, R7)
        for (int i = 0; i < 8; i++) begin
            issue(1,0,0,0,0,0, 0,0, "R2");
            issue(0,0,0,1,0,0, i * 29, i, "R6");
        end
        for (int i = 0; i < 8; i++) issue(0,0,0,0,1,0, 0,0, "R8");
        issue(0,0,0,0,1,0, 0,0, "R10");
        // Overflow: nine calls, ten returns (R9, R10)
        for (int i = 0; i < 9; i++) issue(0,0,0,1,0,0, 200 - i, (i + 3) % 8, "R9");
        for (int i = 0; i < 8; i++) issue(0,0,0,0,1,0, 0,0, "R9");
        issue(0,0,0,0,1,0, 0,0, "R10");
        issue(0,0,0,0,1,0, 0,0, "R10");
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end
endmodule